// File: doc/BRIEF.md
# Erasable Read-Only Memory Device Model

This block is a clocked, synthesizable stand-in for a byte-wide erasable read-only memory. It is meant for simulations of the memory and of the controllers that drive it. The block decodes the pin-level modes from the select, output-gate, programming-voltage and identification-voltage inputs. Those modes are: read, output off, standby, program, program inhibit and identification. Tri-state is modelled by a data bus plus a drive-enable flag. Analog levels, access delays and erasure by light are not modelled. A synchronous clear-all input takes the place of erasure.

Programming can only pull bits from 1 to 0, so each stored byte becomes the AND of its old value and the written byte. A clear-all sets every byte back to 0xFF. The array depth is a parameter, smaller than the 16-bit address space by default. Address bits above the array's index width are not decoded, so higher addresses alias onto the array. While the identification voltage is present, the outputs carry fixed identity bytes in place of array data. A flag reports when identification is requested with address lines raised that should be low.

Top module: `rom_device_model`

## Requirements
- R1: After reset every location reads 0xFF.
- R2: With `ceN`=0, `oeN`=0, `vppHigh`=0 and `a9High`=0, `dataOutEn` is 1 and `dataOut` equals the byte stored at the addressed location.
- R3: With `ceN`=0, `oeN`=1 and `vppHigh`=0, `dataOutEn` is 0.
- R4: With `ceN`=1, `dataOutEn` is 0 whatever `oeN`, `vppHigh` and `a9High` are.
- R5: A rising edge of `ceN` seen at a clock edge while `vppHigh`=1 stores (old byte AND `dataIn`) at the addressed location. A 0 bit is never returned to 1 by programming.
- R6: While `vppHigh`=1, `dataOutEn` is 0. While `ceN` stays high, no location changes.
- R7: With `a9High`=1 and both enables low (`vppHigh`=0), `dataOut` is 0x20 when `addr[0]`=0 and 0x3D when `addr[0]`=1, with `dataOutEn`=1.
- R8: `idAddrErr` is 1 exactly when identification output is active and an address bit other than bit 0 and bit 9 is 1.
- R9: A cycle with `eraseAll`=1 sets every location to 0xFF. It wins over a program write in the same cycle.
- R10: Only the low `MEM_AW` address bits select a location. Addresses that differ only above them reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low reset; fills the array with 0xFF |
| eraseAll | input | 1 | Synchronous clear of the whole array to 0xFF |
| addr | input | ADDR_W | Byte address |
| ceN | input | 1 | Active-low chip select; its rising edge commits a program write |
| oeN | input | 1 | Active-low output gate |
| vppHigh | input | 1 | Programming voltage present on the shared output-gate pin |
| a9High | input | 1 | Identification voltage present on address line 9 |
| dataIn | input | 8 | Byte to program |
| dataOut | output | 8 | Read or identity byte; 0x00 when not driven |
| dataOutEn | output | 1 | 1 when the model drives the data bus |
| idAddrErr | output | 1 | Identification requested with a forbidden address bit high |

## Verification
The assertions assume that `ceN` is held high while reset is active. They also assume that each level of `ceN` lasts at least one clock, so that every program pulse shows up as a registered rising edge. Address and data are assumed stable across the clock edge that commits a write. The stimulus changes inputs one nanosecond after a rising edge and holds them for whole cycles. Program pulses are built from three cycles with address and data fixed. Reset is applied with the chip deselected.

// File: rtl/rom_pkg.sv
package rom_pkg;

  localparam logic [7:0] MFR_CODE = 8'h20;
  localparam logic [7:0] DEV_CODE = 8'h3D;
  localparam logic [7:0] BLANK_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_OUTOFF,
    MODE_READ,
    MODE_IDENT,
    MODE_PROG,
    MODE_INHIBIT
  } romMode_t;

  typedef struct packed {
    logic writeByte;
    logic clearAll;
    logic idSel;
    logic driveOut;
  } romStrobe_t;

endpackage

// File: rtl/rom_ctrl.sv
module rom_ctrl
  import rom_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ID_LINE = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eraseAll,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              vppHigh,
  input  logic              a9High,
  output romStrobe_t        strb,
  output logic              idAddrErr
);

  localparam logic [ADDR_W-1:0] ID_KEEP = ADDR_W'(1) | (ADDR_W'(1) << ID_LINE);

  logic ceNq;
  romMode_t mode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ceNq <= 1'b1;
    else       ceNq <= ceN;
  end

  always_comb begin
    if (vppHigh)     mode = ceN ? MODE_INHIBIT : MODE_PROG;
    else if (ceN)    mode = MODE_STANDBY;
    else if (oeN)    mode = MODE_OUTOFF;
    else if (a9High) mode = MODE_IDENT;
    else             mode = MODE_READ;
  end

  always_comb begin
    strb.writeByte = vppHigh && ceN && !ceNq;
    strb.clearAll  = eraseAll;
    strb.idSel     = (mode == MODE_IDENT);
    strb.driveOut  = (mode == MODE_READ) || (mode == MODE_IDENT);
  end

  assign idAddrErr = strb.idSel && (|(addr & ~ID_KEEP));

  // R4
  standby_nodrive_chk: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> !strb.driveOut);

  // R6
  vpp_nodrive_chk: assert property (@(posedge clk) disable iff (!rstN)
    vppHigh |-> !strb.driveOut);

  // R5
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeByte |=> !strb.writeByte);

  // R8
  err_in_ident_chk: assert property (@(posedge clk) disable iff (!rstN)
    idAddrErr |-> (a9High && !ceN && !oeN && !vppHigh));

endmodule

// File: rtl/rom_data.sv
module rom_data
  import rom_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  romStrobe_t        strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOutEn
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] cells [DEPTH];
  logic [MEM_AW-1:0] idx;
  logic [7:0] idByte;

  assign idx = addr[MEM_AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= BLANK_BYTE;
    end else if (strb.clearAll) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= BLANK_BYTE;
    end else if (strb.writeByte) begin
      cells[idx] <= cells[idx] & dataIn;
    end
  end

  assign idByte = addr[0] ? DEV_CODE : MFR_CODE;

  always_comb begin
    dataOutEn = strb.driveOut;
    if (!strb.driveOut)  dataOut = 8'h00;
    else if (strb.idSel) dataOut = idByte;
    else                 dataOut = cells[idx];
  end

  // R5
  no_bit_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearAll |=> ((cells[0] & ~$past(cells[0])) == 8'h00));

  // R9
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (cells[0] == BLANK_BYTE && cells[DEPTH-1] == BLANK_BYTE));

  // R7
  ident_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.idSel && strb.driveOut) |-> (dataOut == MFR_CODE || dataOut == DEV_CODE));

  // R3
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> (dataOut == 8'h00));

endmodule

// File: rtl/rom_device_model.sv
module rom_device_model
  import rom_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MEM_AW = 10,
  parameter int ID_LINE = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eraseAll,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              vppHigh,
  input  logic              a9High,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOutEn,
  output logic              idAddrErr
);

  romStrobe_t strb;

  rom_ctrl #(.ADDR_W(ADDR_W), .ID_LINE(ID_LINE)) uCtrl (
    .clk(clk), .rstN(rstN), .eraseAll(eraseAll), .addr(addr),
    .ceN(ceN), .oeN(oeN), .vppHigh(vppHigh), .a9High(a9High),
    .strb(strb), .idAddrErr(idAddrErr)
  );

  rom_data #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  // R8
  err_needs_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    idAddrErr |-> dataOutEn);

endmodule

// File: tb/tb_rom_device_model.sv
`timescale 1ns/1ps
module tb_rom_device_model;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eraseAll = 1'b0;
  logic [15:0] addr = '0;
  logic ceN = 1'b1;
  logic oeN = 1'b1;
  logic vppHigh = 1'b0;
  logic a9High = 1'b0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOutEn;
  logic idAddrErr;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  typedef struct {
    logic en;
    logic [7:0] data;
    logic err;
    int req;
  } expItem_t;

  expItem_t sb[$];

  always #2.5 clk = ~clk;

  rom_device_model dut (
    .clk(clk), .rstN(rstN), .eraseAll(eraseAll), .addr(addr),
    .ceN(ceN), .oeN(oeN), .vppHigh(vppHigh), .a9High(a9High),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn),
    .idAddrErr(idAddrErr)
  );

  // monitor: compares pending expectations away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      expItem_t it;
      it = sb.pop_front();
      checks++;
      if (dataOutEn !== it.en || idAddrErr !== it.err ||
          (it.en && dataOut !== it.data)) begin
        errors++;
        $display("FAIL R%0d: en=%b data=%02h err=%b expected en=%b data=%02h err=%b",
                 it.req, dataOutEn, dataOut, idAddrErr, it.en, it.data, it.err);
      end
    end
  end

  task automatic check(input logic [15:0] a, input logic c, input logic o,
                       input logic v, input logic h, input logic en,
                       input logic [7:0] d, input logic err, input int req);
    expItem_t it;
    @(posedge clk); #1;
    addr = a; ceN = c; oeN = o; vppHigh = v; a9High = h;
    it.en = en; it.data = d; it.err = err; it.req = req;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic readAt(input logic [15:0] a, input logic [7:0] d, input int req);
    check(a, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, d, 1'b0, req);
  endtask

  task automatic progByte(input logic [15:0] a, input logic [7:0] d, input logic erase);
    @(posedge clk); #1;
    addr = a; dataIn = d; vppHigh = 1'b1; ceN = 1'b1; oeN = 1'b1; a9High = 1'b0;
    @(posedge clk); #1;
    ceN = 1'b0;
    @(posedge clk); #1;
    ceN = 1'b1; eraseAll = erase;
    @(posedge clk); #1;
    eraseAll = 1'b0; vppHigh = 1'b0;
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: blank after reset, first and last location
    readAt(16'h0000, 8'hFF, 1);
    readAt(16'h03FF, 8'hFF, 1);

    // R5, R2: program then AND with a second byte
    progByte(16'h0005, 8'hF0, 1'b0);
    readAt(16'h0005, 8'hF0, 5);
    progByte(16'h0005, 8'h3C, 1'b0);
    readAt(16'h0005, 8'h30, 5);
    // R5: writing ones cannot restore cleared bits
    progByte(16'h0005, 8'hFF, 1'b0);
    readAt(16'h0005, 8'h30, 5);
    // R2: neighbour untouched
    readAt(16'h0006, 8'hFF, 2);

    // R3: output gate high
    check(16'h0005, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 3);
    // R4: deselected, with gate low and with identification voltage
    check(16'h0005, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 4);
    check(16'h0201, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 4);
    // R6: programming voltage with select low or high never drives
    check(16'h0005, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 6);
    check(16'h0005, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 6);

    // R6: inhibit, voltage present but select never pulsed
    @(posedge clk); #1;
    addr = 16'h0007; dataIn = 8'h00; vppHigh = 1'b1; ceN = 1'b1;
    repeat (4) @(posedge clk);
    #1 vppHigh = 1'b0;
    readAt(16'h0007, 8'hFF, 6);

    // R7: identity bytes
    check(16'h0200, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h20, 1'b0, 7);
    check(16'h0201, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3D, 1'b0, 7);
    // R8: forbidden address bits during identification
    check(16'h0203, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3D, 1'b1, 8);
    check(16'h8200, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h20, 1'b1, 8);
    // R8: no flag without active identification output
    check(16'h8203, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8);
    check(16'h8203, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 8);

    // R10: upper bits alias onto the array
    readAt(16'h0405, 8'h30, 10);
    readAt(16'hFC05, 8'h30, 10);

    // R9: clear all
    @(posedge clk); #1 eraseAll = 1'b1;
    @(posedge clk); #1 eraseAll = 1'b0;
    readAt(16'h0005, 8'hFF, 9);
    // R9: clear wins over program in the same cycle
    progByte(16'h0009, 8'h00, 1'b1);
    readAt(16'h0009, 8'hFF, 9);
    // R5: program still works after clear
    progByte(16'h0009, 8'h81, 1'b0);
    readAt(16'h0009, 8'h81, 5);

    @(posedge clk);
    @(posedge clk);
    finishRun();
  end

endmodule